// File: doc/BRIEF.md
# Multicast Transmit Queue Merger

This block sits on the transmit side of one switch output port. It stores that port's multicast frame references in two FIFOs of unequal depth. At scheduling time it merges each FIFO with the unicast queue of the same class. The unicast queues themselves are linked lists held elsewhere. This block only sees the head of each one: a valid flag, a handle and a timestamp per class.

On the enqueue side, a frame-control handle arrives with its arrival timestamp and a 3-bit transmit priority. The upper bit of the priority picks the FIFO. A full target FIFO refuses the entry by holding `enq_ready` low. An occupancy count for each FIFO is exposed so that an upstream drop policy can read it.

On the dequeue side, the scheduler names a class. The block compares the unicast head of that class with the head of the multicast FIFO that serves it, and presents the older one. A request then removes the presented entry. For a multicast entry the FIFO is popped. For a unicast entry a pop pulse is sent to the external list.

Top module: `mcast_txq_merge`

## Requirements
- R1: An enqueue with priority bit 2 set goes to the high FIFO (occ_hi). An enqueue with bit 2 clear goes to the low FIFO (occ_lo). Bits 1:0 of the priority are ignored.
- R2: Entries leave each multicast FIFO in the order in which they were accepted.
- R3: The high FIFO holds exactly HI_DEPTH (32) entries. When the targeted FIFO is full, `enq_ready` is 0. A refused enqueue changes neither the occupancy nor the stored content.
- R4: The low FIFO holds exactly LO_DEPTH (64) entries. While the low FIFO is full, the high FIFO still accepts entries.
- R5: `occ_hi` and `occ_lo` count the stored entries. Each accepted enqueue adds one and each multicast removal subtracts one. A cycle with both leaves the count unchanged. Every change is visible after the clock edge.
- R6: A dequeue for class c considers only the unicast head of class c (bit c of `uc_valid`, slice c of `uc_handle`/`uc_ts`) and the multicast FIFO selected by bit 2 of c.
- R7: When both heads are valid, the block computes d = (mc_ts − uc_ts) mod 2^TS_W. If bit TS_W−1 of d is set, the multicast head is older and is presented (`out_is_mc`=1). Otherwise the unicast head is presented. Equal timestamps therefore favour unicast.
- R8: When exactly one head is valid, that head is presented whatever the timestamps are. When neither head is valid, `out_valid` is 0.
- R9: `deq_req` while `out_valid` is 1 removes the presented entry. A unicast choice raises `uc_pop` in the same cycle. A multicast choice pops the FIFO at the clock edge and leaves `uc_pop` at 0.
- R10: After reset, both occupancies are 0, `enq_ready` is 1, and no multicast head is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Targeted FIFO can accept |
| enq_handle | input | HANDLE_W | Frame-control handle to store |
| enq_ts | input | TS_W | Arrival timestamp |
| enq_prio | input | 3 | Transmit priority |
| occ_hi | output | $clog2(HI_DEPTH+1) | High FIFO occupancy |
| occ_lo | output | $clog2(LO_DEPTH+1) | Low FIFO occupancy |
| deq_prio | input | 3 | Class being scheduled |
| deq_req | input | 1 | Remove the presented entry |
| uc_valid | input | 8 | Unicast head valid, one bit per class |
| uc_handle | input | 8*HANDLE_W | Unicast head handles, class c in slice c |
| uc_ts | input | 8*TS_W | Unicast head timestamps, class c in slice c |
| out_valid | output | 1 | An entry is presented |
| out_handle | output | HANDLE_W | Presented handle |
| out_is_mc | output | 1 | Presented entry is multicast |
| uc_pop | output | 1 | Advance the unicast list of the scheduled class |

## Verification
The age comparison is driven from a table of timestamp pairs. The pairs cover a clear unicast lead, a clear multicast lead, a tie, a lead that crosses the wrap point in each direction, and the exact half-range boundary. Each pair separates true modular ordering from a plain magnitude compare or a reversed tie rule. Directed sequences fill each FIFO to capacity and drain the high FIFO. These show the depth difference, refusal when full and FIFO order. Other sequences present only one head or none, and name a class whose unicast head and multicast FIFO differ from those in use. These expose mistakes in class mapping and in the valid-only fallback.

// File: rtl/mcq_pkg.sv
// Shared definitions for the multicast transmit queue merger.
package mcq_pkg;
    localparam int PRIO_W    = 3;
    localparam int NUM_CLASS = 1 << PRIO_W;
    localparam int NUM_MCQ   = 2;

    // Which head the merger presents for the scheduled class.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_UC   = 2'd1,
        SRC_MC   = 2'd2
    } src_e;
endpackage

// File: rtl/mcq_fifo.sv
// Single-clock FIFO with a head that can be read combinationally, plus an
// occupancy count.
// Assumes DEPTH is a power of two. A push while full is ignored, and the top
// gates pushes with its ready signal so this never happens in normal use.
module mcq_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign head    = mem[rd_ptr];
    assign count   = CNT_W'(cnt);

    // Store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Advance the pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3: pushes are gated upstream, so a push never meets a full FIFO.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5: the count never exceeds the depth.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R5: a lone accepted push raises the count by one.
    a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/mcq_age_pick.sv
// Chooses between the unicast and multicast heads of one logical queue.
// Ages are compared by modular subtraction on wrapping timestamps. A tie
// favours unicast. A single valid head wins without any comparison.
// clk and rst_n serve only the assertions.
module mcq_age_pick #(
    parameter int TS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uc_v,
    input  logic [TS_W-1:0]   uc_t,
    input  logic              mc_v,
    input  logic [TS_W-1:0]   mc_t,
    output mcq_pkg::src_e     sel
);
    import mcq_pkg::*;

    logic [TS_W-1:0] diff;
    logic            mc_older;

    assign diff     = mc_t - uc_t;
    assign mc_older = diff[TS_W-1];

    // Pick the source from the valid flags and the relative age.
    always_comb begin
        if (uc_v && mc_v)  sel = mc_older ? SRC_MC : SRC_UC;
        else if (uc_v)     sel = SRC_UC;
        else if (mc_v)     sel = SRC_MC;
        else               sel = SRC_NONE;
    end

    // R8: a lone unicast head is chosen.
    a_r8_only_uc: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_v && !mc_v) |-> sel == SRC_UC);
    // R8: a lone multicast head is chosen.
    a_r8_only_mc: assert property (@(posedge clk) disable iff (!rst_n)
        (!uc_v && mc_v) |-> sel == SRC_MC);
    // R8: nothing is chosen when no head is valid.
    a_r8_none: assert property (@(posedge clk) disable iff (!rst_n)
        (!uc_v && !mc_v) |-> sel == SRC_NONE);
    // R7: equal timestamps favour unicast.
    a_r7_tie_uc: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_v && mc_v && uc_t == mc_t) |-> sel == SRC_UC);
endmodule

// File: rtl/mcast_txq_merge.sv
// Per-port multicast transmit queues, merged with the unicast heads.
// Queue 1 (high, HI_DEPTH) serves priorities with bit 2 set, and queue 0
// (low, LO_DEPTH) serves the rest. On dequeue, the scheduled class compares
// its unicast head with its multicast FIFO head and presents the older one.
// Assumes both depths are powers of two and that the external unicast list
// advances on uc_pop.
module mcast_txq_merge #(
    parameter int HANDLE_W = 10,
    parameter int TS_W     = 8,
    parameter int HI_DEPTH = 32,
    parameter int LO_DEPTH = 64,
    localparam int HI_CW   = $clog2(HI_DEPTH + 1),
    localparam int LO_CW   = $clog2(LO_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_valid,
    output logic                          enq_ready,
    input  logic [HANDLE_W-1:0]           enq_handle,
    input  logic [TS_W-1:0]               enq_ts,
    input  logic [2:0]                    enq_prio,
    output logic [HI_CW-1:0]              occ_hi,
    output logic [LO_CW-1:0]              occ_lo,
    input  logic [2:0]                    deq_prio,
    input  logic                          deq_req,
    input  logic [7:0]                    uc_valid,
    input  logic [8*HANDLE_W-1:0]         uc_handle,
    input  logic [8*TS_W-1:0]             uc_ts,
    output logic                          out_valid,
    output logic [HANDLE_W-1:0]           out_handle,
    output logic                          out_is_mc,
    output logic                          uc_pop
);
    import mcq_pkg::*;

    localparam int EW    = HANDLE_W + TS_W;
    localparam int MAX_D = (HI_DEPTH > LO_DEPTH) ? HI_DEPTH : LO_DEPTH;
    localparam int CNT_W = $clog2(MAX_D + 1);

    logic [NUM_MCQ-1:0] q_push, q_pop, q_empty, q_full;
    logic [EW-1:0]      q_head [NUM_MCQ];
    logic [CNT_W-1:0]   q_cnt  [NUM_MCQ];
    logic               enq_q, deq_q;
    logic               mc_pop;
    logic               uc_v_sel;
    logic [HANDLE_W-1:0] uc_h_sel, mc_h_sel;
    logic [TS_W-1:0]     uc_t_sel, mc_t_sel;
    src_e               sel;

    // The upper priority bit picks the multicast FIFO on both sides.
    assign enq_q     = enq_prio[2];
    assign deq_q     = deq_prio[2];
    assign enq_ready = !q_full[enq_q];

    // Two FIFOs that differ only in depth.
    for (genvar q = 0; q < NUM_MCQ; q++) begin : g_mcq
        localparam int DEP = (q == 1) ? HI_DEPTH : LO_DEPTH;
        assign q_push[q] = enq_valid && enq_ready && (enq_q == 1'(q));
        assign q_pop[q]  = mc_pop && (deq_q == 1'(q));
        mcq_fifo #(.DEPTH(DEP), .W(EW), .CNT_W(CNT_W)) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[q]),
            .din   ({enq_handle, enq_ts}),
            .pop   (q_pop[q]),
            .head  (q_head[q]),
            .empty (q_empty[q]),
            .full  (q_full[q]),
            .count (q_cnt[q])
        );
    end

    assign occ_hi = q_cnt[1][HI_CW-1:0];
    assign occ_lo = q_cnt[0][LO_CW-1:0];

    // Gather the two heads that form the scheduled logical queue.
    always_comb begin
        uc_v_sel = uc_valid[deq_prio];
        uc_h_sel = uc_handle[deq_prio*HANDLE_W +: HANDLE_W];
        uc_t_sel = uc_ts[deq_prio*TS_W +: TS_W];
        {mc_h_sel, mc_t_sel} = q_head[deq_q];
    end

    mcq_age_pick #(.TS_W(TS_W)) i_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .uc_v  (uc_v_sel),
        .uc_t  (uc_t_sel),
        .mc_v  (!q_empty[deq_q]),
        .mc_t  (mc_t_sel),
        .sel   (sel)
    );

    // Present the winner and route the removal request to its owner.
    always_comb begin
        out_valid  = (sel != SRC_NONE);
        out_is_mc  = (sel == SRC_MC);
        out_handle = out_is_mc ? mc_h_sel : uc_h_sel;
        uc_pop     = deq_req && (sel == SRC_UC);
        mc_pop     = deq_req && (sel == SRC_MC);
    end

    // R1: an accepted high-priority enqueue with no high pop raises occ_hi.
    a_r1_route_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push[1] && !q_pop[1]) |=> occ_hi == $past(occ_hi) + 1'b1);
    // R1: an accepted low-priority enqueue leaves occ_hi alone when the high FIFO is idle.
    a_r1_route_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready && !enq_prio[2] && !q_pop[1]) |=> $stable(occ_hi));
    // R9: the unicast pop only fires for a valid unicast head.
    a_r9_uc_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        uc_pop |-> uc_v_sel && !out_is_mc);
endmodule

// File: tb/test_mcast_txq_merge.sv
module test_mcast_txq_merge;
    localparam int HW = 10;
    localparam int TW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enq_valid = 1'b0;
    logic           enq_ready;
    logic [HW-1:0]  enq_handle = '0;
    logic [TW-1:0]  enq_ts = '0;
    logic [2:0]     enq_prio = '0;
    logic [5:0]     occ_hi;
    logic [6:0]     occ_lo;
    logic [2:0]     deq_prio = '0;
    logic           deq_req = 1'b0;
    logic [7:0]     uc_valid = '0;
    logic [8*HW-1:0] uc_handle = '0;
    logic [8*TW-1:0] uc_ts = '0;
    logic           out_valid;
    logic [HW-1:0]  out_handle;
    logic           out_is_mc;
    logic           uc_pop;

    int n_chk = 0;
    int n_fail = 0;
    logic last_ready;
    bit done = 0;

    mcast_txq_merge i_mcast_txq_merge (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_handle(enq_handle), .enq_ts(enq_ts), .enq_prio(enq_prio),
        .occ_hi(occ_hi), .occ_lo(occ_lo), .deq_prio(deq_prio), .deq_req(deq_req),
        .uc_valid(uc_valid), .uc_handle(uc_handle), .uc_ts(uc_ts),
        .out_valid(out_valid), .out_handle(out_handle), .out_is_mc(out_is_mc),
        .uc_pop(uc_pop)
    );

    always #5 clk = ~clk;

    // Age vectors: {uc_ts, mc_ts, expected out_is_mc} (R7)
    localparam logic [16:0] VEC [7] = '{
        {8'd10,  8'd20,  1'b0},
        {8'd20,  8'd10,  1'b1},
        {8'd15,  8'd15,  1'b0},
        {8'd250, 8'd5,   1'b0},
        {8'd5,   8'd250, 1'b1},
        {8'd0,   8'd128, 1'b1},
        {8'd0,   8'd127, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FIFO check FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int prio, input int h, input int ts);
        @(negedge clk);
        enq_valid = 1'b1; enq_prio = 3'(prio); enq_handle = HW'(h); enq_ts = TW'(ts);
        #1 last_ready = enq_ready;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        deq_req = 1'b1;
        @(negedge clk);
        deq_req = 1'b0;
    endtask

    task automatic set_uc(input int c, input bit v, input int h, input int ts);
        uc_valid[c] = v;
        uc_handle[c*HW +: HW] = HW'(h);
        uc_ts[c*TW +: TW] = TW'(ts);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10 occ_hi", occ_hi, 0);
        chk("R10 occ_lo", occ_lo, 0);
        chk("R10 enq_ready", enq_ready, 1);
        chk("R10 out_valid", out_valid, 0);

        // R7: age table walk on class 4 (high FIFO)
        deq_prio = 3'd4;
        for (int i = 0; i < 7; i++) begin
            push(4, i + 1, int'(VEC[i][8:1]));
            set_uc(4, 1'b1, 16'hA0 + i, int'(VEC[i][16:9]));
            #1;
            chk("R7 winner", out_is_mc, int'(VEC[i][0]));
            chk("R7 handle", out_handle, VEC[i][0] ? i + 1 : 16'hA0 + i);
            set_uc(4, 1'b0, 0, 0);
            pop();
        end
        chk("R9 mc pop drains", occ_hi, 0);

        // R8: only multicast valid, timestamp far in the future
        push(5, 33, 200);
        set_uc(4, 1'b0, 0, 0);
        #1;
        chk("R8 only mc valid", out_valid, 1);
        chk("R8 only mc chosen", out_is_mc, 1);
        pop();
        chk("R8 mc removed", occ_hi, 0);

        // R8/R9: only unicast valid, and the request pulses uc_pop
        set_uc(4, 1'b1, 77, 0);
        @(negedge clk);
        deq_req = 1'b1;
        #1;
        chk("R8 only uc chosen", out_is_mc, 0);
        chk("R8 uc handle", out_handle, 77);
        chk("R9 uc_pop", uc_pop, 1);
        @(negedge clk);
        deq_req = 1'b0;
        chk("R9 uc choice leaves occ_hi", occ_hi, 0);
        set_uc(4, 1'b0, 0, 0);
        #1;
        chk("R8 none valid", out_valid, 0);

        // R3/R1: fill the high FIFO through all four high priorities
        for (int k = 0; k < 32; k++) begin
            push(4 + (k % 4), k, k);
            if (!last_ready) chk("R3 ready while filling", 0, 1);
        end
        chk("R3 occ_hi full", occ_hi, 32);
        chk("R1 occ_lo untouched", occ_lo, 0);
        push(7, 99, 99);
        chk("R3 refused ready", last_ready, 0);
        chk("R3 refused occ", occ_hi, 32);

        // R2: drain in order via class 5
        deq_prio = 3'd5;
        for (int k = 0; k < 32; k++) begin
            #1;
            chk("R2 order", out_handle, k);
            pop();
        end
        chk("R3 refused entry absent", out_valid, 0);

        // R4/R1: fill the low FIFO
        for (int k = 0; k < 64; k++) push(k % 4, k, k);
        chk("R4 occ_lo full", occ_lo, 64);
        @(negedge clk);
        enq_prio = 3'd1;
        #1 chk("R4 low refuses", enq_ready, 0);
        enq_prio = 3'd4;
        #1 chk("R4 high still accepts", enq_ready, 1);

        // R6: class 2 uses its own unicast head and the low FIFO
        set_uc(2, 1'b1, 55, 100);
        set_uc(5, 1'b1, 66, 0);
        deq_prio = 3'd2;
        #1;
        chk("R6 class2 mc older", out_is_mc, 1);
        chk("R6 class2 handle", out_handle, 0);
        deq_prio = 3'd6;
        #1;
        chk("R6 class6 sees nothing", out_valid, 0);
        set_uc(5, 1'b0, 0, 0);
        set_uc(2, 1'b0, 0, 0);

        // R5: simultaneous accept and removal on the low FIFO
        deq_prio = 3'd1;
        pop();
        chk("R5 pop decrements", occ_lo, 63);
        @(negedge clk);
        enq_valid = 1'b1; enq_prio = 3'd0; enq_handle = 10'd500; enq_ts = 8'd70;
        deq_req = 1'b1;
        @(negedge clk);
        enq_valid = 1'b0; deq_req = 1'b0;
        chk("R5 push+pop steady", occ_lo, 63);
        #1 chk("R2 next low head", out_handle, 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule